// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block gathers 96 level-sensitive interrupt lines into three groups of 32 and presents them to a processor through a small 32-bit register port. A per-line control word chooses which of two processor outputs the line drives: the normal request output or the fast request output. The same word also sets a 6-bit urgency value for the line. Software can block each line with a mask bit and can raise or drop any line itself. It can read the raw inputs and the masked pending state of each output class.

For each class, a search picks the most urgent pending line. The controller latches that line's number as soon as nothing is held for the class. The result then stays frozen, and it stays readable, until software acknowledges it through a control write. Only after that acknowledge does a fresh search take place. A configuration word offers a software reset, which returns every state element to its power-up value. A status word reports when that reset is complete, and a fixed read-only word gives the revision.

Top module: `prioirq_ctrl`

## Requirements
- R1: After reset, every mask bit reads 1, every software-raised bit reads 0 and every line control word reads 0. No result is held, and both request outputs are low.
- R2: Line n belongs to group n>>5 at bit n&31. Group g owns the addresses 0x80+0x20*g to 0x9F+0x20*g. Word +0x00 is the raw input (read-only), +0x04 the mask, +0x08 mask-clear, +0x0C mask-set, +0x10 software-raise, +0x14 software-drop, +0x18 pending normal class and +0x1C pending fast class (both read-only).
- R3: Writing +0x04 replaces the whole mask. A 1 written to +0x08 clears that mask bit, a 1 written to +0x0C sets it, and bits written as 0 leave the mask unchanged. Words +0x08, +0x0C and +0x14 read as zero.
- R4: A line is pending when it is raised by its input or by software and its mask bit is 0. A pending line shows in the fast-class word when bit 0 of its control word is 1, and in the normal-class word otherwise.
- R5: A 1 written to +0x10 raises that line by software, a 1 written to +0x14 drops it, and +0x10 reads back the software-raised bits.
- R6: The control word of line n sits at 0x100+4*n. Bit 0 selects the fast class and bits 7:2 hold the urgency. Only these bits are stored and read back; all other bits read 0.
- R7: When a class holds no result and has a line pending, the next clock edge latches that class's winner. The winner is the line with the lowest urgency value, and on a tie the lowest line number wins. Address 0x40 (normal class) and 0x44 (fast class) read the line number in bits 6:0 and the held flag in bit 31.
- R8: A held result and its line number do not change, whatever happens to the pending lines, until that class is acknowledged.
- R9: Writing 1 to bit 0 of 0x48 acknowledges the normal class, and bit 1 acknowledges the fast class. The held flag clears at that edge, and a new search can latch at the following edge. 0x48 reads as zero.
- R10: Each request output is high while its class holds a result, or while any line of that class is pending. The pending case acts combinationally, without waiting for a clock.
- R11: Writing 1 to bit 1 of 0x10 resets all state to the R1 values. Bit 0 of 0x14 then reads 0 for one cycle and 1 afterwards. Bit 0 of 0x10 is a stored power-control bit that reads back, and bit 1 reads 0.
- R12: Address 0x00 reads the revision parameter, with the major number in bits 7:4 and the minor number in bits 3:0. Any unmapped address reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lines_i | input | 96 | Interrupt input lines, active high level |
| wr_en_i | input | 1 | Register write strobe for this cycle |
| addr_i | input | 10 | Byte address of the register access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| irq_o | output | 1 | Normal-class request to the processor |
| fiq_o | output | 1 | Fast-class request to the processor |

## Verification
The assertions check several rules on every cycle. A held result and its line number stay frozen until acknowledged. An acknowledge clears the held flag at the next edge. A free class latches exactly when something was pending. A software reset empties both classes. Mask-set writes touch only the bits written as 1, and a reported winner is always one of the pending lines. The choice of winner needs the bench's scenarios, because it depends on urgency, ties and steering. So do the address map, the combinational path from input to output, and the timing of the reset-done flag. The bench checks all of these against a model built from the requirements, over directed and random register traffic.

// File: rtl/pic_pkg.sv
package pic_pkg;

    typedef enum logic [2:0] {
        W_RAW  = 3'd0,
        W_MASK = 3'd1,
        W_MCLR = 3'd2,
        W_MSET = 3'd3,
        W_SSET = 3'd4,
        W_SCLR = 3'd5,
        W_PIRQ = 3'd6,
        W_PFIQ = 3'd7
    } win_e;

    localparam logic [9:0] A_REV     = 10'h000;
    localparam logic [9:0] A_CFG     = 10'h010;
    localparam logic [9:0] A_STAT    = 10'h014;
    localparam logic [9:0] A_WIN_N   = 10'h040;
    localparam logic [9:0] A_WIN_F   = 10'h044;
    localparam logic [9:0] A_ACK     = 10'h048;
    localparam int         LVL_BASE  = 256;

    typedef struct packed {
        logic [31:0] mask;
        logic [31:0] sw;
    } bank_st_t;

endpackage

// File: rtl/pic_bank.sv
module pic_bank
    import pic_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        soft_rst_i,
    input  logic        we_i,
    input  win_e        sel_i,
    input  logic [31:0] wdata_i,
    input  logic [31:0] raw_i,
    input  logic [31:0] steer_i,
    output logic [31:0] mask_o,
    output logic [31:0] sw_o,
    output logic [31:0] irq_pend_o,
    output logic [31:0] fiq_pend_o
);
    bank_st_t st_d, st_q;
    logic [31:0] pend;

    always_comb begin
        st_d = st_q;
        if (soft_rst_i) begin
            st_d.mask = '1;
            st_d.sw   = '0;
        end else if (we_i) begin
            case (sel_i)
                W_MASK:  st_d.mask = wdata_i;
                W_MCLR:  st_d.mask = st_q.mask & ~wdata_i;
                W_MSET:  st_d.mask = st_q.mask | wdata_i;
                W_SSET:  st_d.sw   = st_q.sw | wdata_i;
                W_SCLR:  st_d.sw   = st_q.sw & ~wdata_i;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.mask <= '1;
            st_q.sw   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend       = (raw_i | st_q.sw) & ~st_q.mask;
    assign irq_pend_o = pend & ~steer_i;
    assign fiq_pend_o = pend & steer_i;
    assign mask_o     = st_q.mask;
    assign sw_o       = st_q.sw;

    assert_mset_only_ones_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        we_i && sel_i == W_MSET && !soft_rst_i
        |=> ((mask_o & $past(wdata_i)) == $past(wdata_i)) &&
            ((mask_o & ~$past(wdata_i)) == ($past(mask_o) & ~$past(wdata_i))));

    assert_mclr_only_ones_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        we_i && sel_i == W_MCLR && !soft_rst_i
        |=> ((mask_o & $past(wdata_i)) == '0) &&
            ((mask_o & ~$past(wdata_i)) == ($past(mask_o) & ~$past(wdata_i))));

    assert_sw_drop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        we_i && sel_i == W_SCLR && !soft_rst_i
        |=> (sw_o & $past(wdata_i)) == '0);

endmodule

// File: rtl/pic_pick.sv
module pic_pick #(
    parameter int N  = 96,
    parameter int PW = 6,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]         pend_i,
    input  logic [N-1:0][PW-1:0] prio_i,
    output logic                 any_o,
    output logic [IW-1:0]        id_o
);
    logic [PW-1:0] best_p;

    // Strict less-than keeps the earlier (lower-numbered) line on a tie.
    always_comb begin
        any_o  = 1'b0;
        id_o   = '0;
        best_p = '1;
        for (int i = 0; i < N; i++) begin
            if (pend_i[i] && (!any_o || prio_i[i] < best_p)) begin
                any_o  = 1'b1;
                id_o   = IW'(i);
                best_p = prio_i[i];
            end
        end
    end

    always_comb begin
        if (any_o) begin
            assert_winner_pending_R7: assert (pend_i[id_o]);
        end
    end

endmodule

// File: rtl/prioirq_ctrl.sv
module prioirq_ctrl
    import pic_pkg::*;
#(
    parameter int         LINES  = 96,
    parameter int         PRIO_W = 6,
    parameter logic [7:0] REV    = 8'h21
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [LINES-1:0] lines_i,
    input  logic             wr_en_i,
    input  logic [9:0]       addr_i,
    input  logic [31:0]      wdata_i,
    output logic [31:0]      rdata_o,
    output logic             irq_o,
    output logic             fiq_o
);
    localparam int NBANK = LINES / 32;
    localparam int ID_W  = $clog2(LINES);

    typedef struct packed {
        logic                         ih;
        logic [ID_W-1:0]              iid;
        logic                         fh;
        logic [ID_W-1:0]              fid;
        logic                         idle;
        logic                         done;
        logic [LINES-1:0]             steer;
        logic [LINES-1:0][PRIO_W-1:0] prio;
    } st_t;

    st_t st_d, st_q;

    logic        in_bank;
    logic [1:0]  bank_idx;
    win_e        sel;
    logic        soft_rst, ack_n, ack_f;

    logic [NBANK-1:0][31:0] mask_w, sw_w, ipend_w, fpend_w;
    logic [LINES-1:0]       ipend, fpend;
    logic                   i_any, f_any;
    logic [ID_W-1:0]        i_id, f_id;

    assign in_bank  = (addr_i[9:8] == 2'b00) && addr_i[7];
    assign bank_idx = addr_i[6:5];
    assign sel      = win_e'(addr_i[4:2]);
    assign soft_rst = wr_en_i && addr_i == A_CFG && wdata_i[1];
    assign ack_n    = wr_en_i && addr_i == A_ACK && wdata_i[0];
    assign ack_f    = wr_en_i && addr_i == A_ACK && wdata_i[1];

    function automatic logic [9:0] lvl_addr(input int n);
        return 10'(LVL_BASE + 4 * n);
    endfunction

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        pic_bank u_bank (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .soft_rst_i (soft_rst),
            .we_i       (wr_en_i && in_bank && bank_idx == 2'(b)),
            .sel_i      (sel),
            .wdata_i    (wdata_i),
            .raw_i      (lines_i[b*32 +: 32]),
            .steer_i    (st_q.steer[b*32 +: 32]),
            .mask_o     (mask_w[b]),
            .sw_o       (sw_w[b]),
            .irq_pend_o (ipend_w[b]),
            .fiq_pend_o (fpend_w[b])
        );
    end

    assign ipend = ipend_w;
    assign fpend = fpend_w;

    pic_pick #(.N(LINES), .PW(PRIO_W), .IW(ID_W)) u_pick_n (
        .pend_i (ipend),
        .prio_i (st_q.prio),
        .any_o  (i_any),
        .id_o   (i_id)
    );

    pic_pick #(.N(LINES), .PW(PRIO_W), .IW(ID_W)) u_pick_f (
        .pend_i (fpend),
        .prio_i (st_q.prio),
        .any_o  (f_any),
        .id_o   (f_id)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b1;
        if (st_q.ih) begin
            if (ack_n) st_d.ih = 1'b0;
        end else if (i_any) begin
            st_d.ih  = 1'b1;
            st_d.iid = i_id;
        end
        if (st_q.fh) begin
            if (ack_f) st_d.fh = 1'b0;
        end else if (f_any) begin
            st_d.fh  = 1'b1;
            st_d.fid = f_id;
        end
        if (wr_en_i && addr_i == A_CFG) st_d.idle = wdata_i[0];
        for (int i = 0; i < LINES; i++) begin
            if (wr_en_i && addr_i == lvl_addr(i)) begin
                st_d.steer[i] = wdata_i[0];
                st_d.prio[i]  = wdata_i[2 +: PRIO_W];
            end
        end
        if (soft_rst) st_d = '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign irq_o = st_q.ih | i_any;
    assign fiq_o = st_q.fh | f_any;

    always_comb begin
        rdata_o = '0;
        if (addr_i == A_REV) begin
            rdata_o[7:0] = REV;
        end else if (addr_i == A_CFG) begin
            rdata_o[0] = st_q.idle;
        end else if (addr_i == A_STAT) begin
            rdata_o[0] = st_q.done;
        end else if (addr_i == A_WIN_N) begin
            rdata_o[31]       = st_q.ih;
            rdata_o[ID_W-1:0] = st_q.iid;
        end else if (addr_i == A_WIN_F) begin
            rdata_o[31]       = st_q.fh;
            rdata_o[ID_W-1:0] = st_q.fid;
        end
        for (int b = 0; b < NBANK; b++) begin
            if (in_bank && bank_idx == 2'(b)) begin
                case (sel)
                    W_RAW:   rdata_o = lines_i[b*32 +: 32];
                    W_MASK:  rdata_o = mask_w[b];
                    W_SSET:  rdata_o = sw_w[b];
                    W_PIRQ:  rdata_o = ipend_w[b];
                    W_PFIQ:  rdata_o = fpend_w[b];
                    default: rdata_o = '0;
                endcase
            end
        end
        for (int i = 0; i < LINES; i++) begin
            if (addr_i == lvl_addr(i)) begin
                rdata_o                 = '0;
                rdata_o[0]              = st_q.steer[i];
                rdata_o[2 +: PRIO_W]    = st_q.prio[i];
            end
        end
    end

    assert_freeze_n_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.ih && !ack_n && !soft_rst |=> st_q.ih && $stable(st_q.iid));

    assert_freeze_f_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.fh && !ack_f && !soft_rst |=> st_q.fh && $stable(st_q.fid));

    assert_ack_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.ih && ack_n && !soft_rst |=> !st_q.ih);

    assert_latch_when_pending_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !st_q.ih && !soft_rst |=> st_q.ih == $past(i_any));

    assert_soft_reset_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        soft_rst |=> !st_q.ih && !st_q.fh && !st_q.done);

endmodule

// File: tb/sim_prioirq_ctrl.sv
`timescale 1ns/1ps
module sim_prioirq_ctrl;
    localparam int LINES = 96;
    localparam logic [7:0] REV = 8'h21;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [95:0] lines = '0;
    logic        we = 1'b0;
    logic [9:0]  addr = '0;
    logic [31:0] wd = '0;
    logic [31:0] rd;
    logic        irq, fiq;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    prioirq_ctrl #(.LINES(LINES), .PRIO_W(6), .REV(REV)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .lines_i(lines), .wr_en_i(we),
        .addr_i(addr), .wdata_i(wd), .rdata_o(rd), .irq_o(irq), .fiq_o(fiq)
    );

    // Reference model, built from the requirements
    logic [31:0] m_mask [3];
    logic [31:0] m_sw   [3];
    logic        m_steer[96];
    logic [5:0]  m_prio [96];
    logic        m_ih, m_fh, m_idle, m_done;
    int          m_iid, m_fid;

    function automatic logic [95:0] pvec(input logic fast);
        logic [95:0] v;
        for (int i = 0; i < 96; i++) begin
            logic p;
            p = (lines[i] | m_sw[i/32][i%32]) & ~m_mask[i/32][i%32];
            v[i] = p && (m_steer[i] == fast);
        end
        return v;
    endfunction

    function automatic int pick(input logic [95:0] v);
        int best;
        best = -1;
        for (int i = 0; i < 96; i++)
            if (v[i] && (best < 0 || m_prio[i] < m_prio[best])) best = i;
        return best;
    endfunction

    task automatic model_reset();
        for (int b = 0; b < 3; b++) begin m_mask[b] = '1; m_sw[b] = '0; end
        for (int i = 0; i < 96; i++) begin m_steer[i] = 1'b0; m_prio[i] = '0; end
        m_ih = 0; m_fh = 0; m_iid = 0; m_fid = 0; m_idle = 0; m_done = 0;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            model_reset();
        end else if (we && addr == 10'h010 && wd[1]) begin
            model_reset();
        end else begin
            logic [95:0] iv, fv;
            iv = pvec(1'b0);
            fv = pvec(1'b1);
            m_done = 1;
            if (m_ih) begin
                if (we && addr == 10'h048 && wd[0]) m_ih = 0;
            end else if (iv != 0) begin
                m_ih = 1; m_iid = pick(iv);
            end
            if (m_fh) begin
                if (we && addr == 10'h048 && wd[1]) m_fh = 0;
            end else if (fv != 0) begin
                m_fh = 1; m_fid = pick(fv);
            end
            if (we) begin
                if (addr == 10'h010) m_idle = wd[0];
                if (addr >= 10'h080 && addr < 10'h0E0) begin
                    int b, w;
                    b = (int'(addr) - 128) >> 5;
                    w = (int'(addr) >> 2) & 7;
                    case (w)
                        1: m_mask[b] = wd;
                        2: m_mask[b] = m_mask[b] & ~wd;
                        3: m_mask[b] = m_mask[b] | wd;
                        4: m_sw[b]   = m_sw[b] | wd;
                        5: m_sw[b]   = m_sw[b] & ~wd;
                        default: ;
                    endcase
                end
                if (addr >= 10'h100 && int'(addr) < 256 + 4*96 && addr[1:0] == 2'b00) begin
                    int n;
                    n = (int'(addr) - 256) / 4;
                    m_steer[n] = wd[0];
                    m_prio[n]  = wd[7:2];
                end
            end
        end
    end

    function automatic logic [31:0] exp_rd(input logic [9:0] a);
        logic [95:0] iv, fv;
        iv = pvec(1'b0);
        fv = pvec(1'b1);
        if (a == 10'h000) return {24'b0, REV};
        if (a == 10'h010) return {31'b0, m_idle};
        if (a == 10'h014) return {31'b0, m_done};
        if (a == 10'h040) return {m_ih, 24'b0, 7'(m_iid)};
        if (a == 10'h044) return {m_fh, 24'b0, 7'(m_fid)};
        if (a >= 10'h080 && a < 10'h0E0) begin
            int b, w;
            b = (int'(a) - 128) >> 5;
            w = (int'(a) >> 2) & 7;
            case (w)
                0: return lines[b*32 +: 32];
                1: return m_mask[b];
                4: return m_sw[b];
                6: return iv[b*32 +: 32];
                7: return fv[b*32 +: 32];
                default: return 32'h0;
            endcase
        end
        if (a >= 10'h100 && int'(a) < 256 + 4*96 && a[1:0] == 2'b00) begin
            int n;
            n = (int'(a) - 256) / 4;
            return {24'b0, m_prio[n], 1'b0, m_steer[n]};
        end
        return 32'h0;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wd = d;
    endtask

    task automatic rdchk(input string tag, input logic [9:0] a);
        @(negedge clk);
        we = 1'b0; addr = a;
        #1;
        chk(tag, rd, exp_rd(a));
    endtask

    task automatic outchk(input string tag);
        chk({tag, " irq_o"}, {31'b0, irq}, {31'b0, m_ih | (pvec(1'b0) != 0)});
        chk({tag, " fiq_o"}, {31'b0, fiq}, {31'b0, m_fh | (pvec(1'b1) != 0)});
    endtask

    task automatic set_lines(input logic [95:0] v, input string tag);
        @(negedge clk);
        we = 1'b0; lines = v;
        #1;
        outchk(tag);
    endtask

    function automatic logic [31:0] lvl(input int pr, input logic fast);
        return {24'b0, 6'(pr), 1'b0, fast};
    endfunction

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 / R12: reset state and revision
        rdchk("R12 revision", 10'h000);
        rdchk("R1 mask reset g0", 10'h084);
        rdchk("R1 mask reset g2", 10'h0C4);
        rdchk("R1 sw reset", 10'h090);
        rdchk("R1 level reset", 10'h17C);
        rdchk("R1 no result held", 10'h040);
        rdchk("R11 reset done flag", 10'h014);
        rdchk("R12 unmapped reads 0", 10'h3F0);
        chk("R1 irq_o low", {31'b0, irq}, 32'h0);
        chk("R1 fiq_o low", {31'b0, fiq}, 32'h0);

        // R6: level word storage, junk bits dropped
        wr(10'h100 + 10'd148, 32'hFFFF_FF2A);
        rdchk("R6 level readback", 10'h100 + 10'd148);
        chk("R6 level value", rd, 32'h0000_0028);
        wr(10'h100 + 10'd148, lvl(10, 1'b0));

        // R2 / R3 / R4: line 37 = group 1 bit 5
        wr(10'h0A8, 32'h0000_0020);
        rdchk("R3 mask-clear effect", 10'h0A4);
        rdchk("R3 mask-clear reads 0", 10'h0A8);
        set_lines(96'd1 << 37, "R10 combinational request");
        rdchk("R2 raw input word", 10'h0A0);
        chk("R2 line 37 at group 1 bit 5", rd, 32'h0000_0020);
        rdchk("R4 pending normal word", 10'h0B8);
        rdchk("R7 winner latched", 10'h040);
        chk("R7 winner line 37", rd, 32'h8000_0025);

        // R8: frozen while held
        wr(10'h100 + 10'd12, lvl(0, 1'b0));
        wr(10'h088, 32'h0000_0008);
        set_lines((96'd1 << 37) | (96'd1 << 3), "R8 more urgent arrives");
        rdchk("R8 result frozen", 10'h040);
        chk("R8 still line 37", rd, 32'h8000_0025);
        set_lines('0, "R8 inputs gone");
        rdchk("R8 frozen after drop", 10'h040);

        // R9: acknowledge
        wr(10'h048, 32'h1);
        rdchk("R9 held cleared", 10'h040);
        rdchk("R9 control reads 0", 10'h048);
        outchk("R9 after ack");

        // R7 ties: lines 40 and 70 same urgency
        wr(10'h100 + 10'd160, lvl(3, 1'b0));
        wr(10'h100 + 10'd280, lvl(3, 1'b0));
        wr(10'h0A4, 32'h0);
        wr(10'h0C4, 32'h0);
        set_lines((96'd1 << 40) | (96'd1 << 70), "R7 tie setup");
        rdchk("R7 tie lowest number", 10'h040);
        chk("R7 tie winner 40", rd, 32'h8000_0028);
        wr(10'h100 + 10'd280, lvl(2, 1'b0));
        wr(10'h048, 32'h1);
        @(negedge clk); we = 1'b0;
        rdchk("R7 urgency beats number", 10'h040);
        chk("R7 winner 70", rd, 32'h8000_0046);

        // R4 / R5 fast class via software raise on line 9
        wr(10'h048, 32'h1);
        set_lines('0, "R5 clear inputs");
        wr(10'h100 + 10'd36, lvl(5, 1'b1));
        wr(10'h080 + 10'h04, 32'hFFFF_FDFF);
        wr(10'h090, 32'h0000_0200);
        rdchk("R5 software raise readback", 10'h090);
        rdchk("R4 pending fast word", 10'h09C);
        rdchk("R4 not in normal word", 10'h098);
        rdchk("R7 fast winner", 10'h044);
        outchk("R10 fast held");
        wr(10'h094, 32'h0000_0200);
        rdchk("R5 software drop", 10'h090);
        rdchk("R3 software-drop reads 0", 10'h094);
        wr(10'h048, 32'h2);
        rdchk("R9 fast ack", 10'h044);
        wr(10'h08C, 32'h0000_0200);
        rdchk("R3 mask-set", 10'h084);
        rdchk("R3 mask-set reads 0", 10'h08C);

        // R11: power bit and software reset
        wr(10'h010, 32'h1);
        rdchk("R11 power bit stored", 10'h010);
        wr(10'h0B0, 32'h1);
        wr(10'h010, 32'h2);
        rdchk("R11 done low after reset", 10'h014);
        rdchk("R11 done high again", 10'h014);
        rdchk("R11 mask restored", 10'h0A4);
        rdchk("R11 sw restored", 10'h0B0);
        rdchk("R11 level restored", 10'h100 + 10'd160);
        rdchk("R11 power bit cleared", 10'h010);

        // Random traffic
        for (int it = 0; it < 600; it++) begin
            int op, g;
            op = $urandom_range(0, 8);
            g  = $urandom_range(0, 2);
            case (op)
                0: wr(10'(256 + 4 * $urandom_range(0, 95)),
                      {$urandom_range(0, 3) << 2} | 32'($urandom_range(0, 1)) | 32'hFF00_0000);
                1: wr(10'(128 + 32 * g + 8), $urandom());
                2: wr(10'(128 + 32 * g + 12), $urandom() & $urandom());
                3: wr(10'(128 + 32 * g + 16), $urandom() & $urandom() & $urandom());
                4: wr(10'(128 + 32 * g + 20), $urandom());
                5: set_lines({$urandom(), $urandom(), $urandom()} &
                             {$urandom(), $urandom(), $urandom()} &
                             {$urandom(), $urandom(), $urandom()}, "R10 random");
                6: wr(10'h048, 32'($urandom_range(1, 3)));
                7: wr(10'(128 + 32 * g + 4), $urandom() | $urandom());
                default: @(negedge clk);
            endcase
            case ($urandom_range(0, 4))
                0: rdchk("R7 random normal winner", 10'h040);
                1: rdchk("R7 random fast winner", 10'h044);
                2: rdchk("R4 random normal pending", 10'(128 + 32 * g + 24));
                3: rdchk("R4 random fast pending", 10'(128 + 32 * g + 28));
                default: rdchk("R3 random mask", 10'(128 + 32 * g + 4));
            endcase
            outchk("R10 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule